// File: doc/BRIEF.md
# Non-Restoring Sequential Integer Divider

This block divides one integer operand by another over many clock cycles. It produces one quotient bit per iteration by the non-restoring method. At each step the partial remainder is shifted, and the divisor is then added to it or subtracted from it, depending on the remainder's sign. Every iteration is deliberately spread across two clock cycles: a shift phase and an add/subtract phase. A single shared carry-select adder serves both the iteration steps and the final remainder correction.

Operands are magnitude-converted before the loop. The quotient and remainder signs are restored after the loop. A mode input picks full-width or half-width operation, so a half-width division finishes in about half the time. A zero divisor bypasses the loop and completes almost at once, with a flag set. A host pulses `start_i` with the operands present and waits for the one-cycle `done_o` pulse. The results then stay on the outputs until the next completion.

Top module: `nr_divider`

## Requirements
- R1: With `signed_i`=0 and `wide_i`=1, the quotient is floor(dividend/divisor) and the remainder is dividend − quotient·divisor, with 0 ≤ remainder < divisor, all as 64-bit unsigned numbers.
- R2: With `signed_i`=1 and `wide_i`=1, the operands are two's complement. The quotient is truncated toward zero and is negative exactly when the operand signs differ. The remainder carries the sign of the dividend and has a magnitude below that of the divisor.
- R3: With `wide_i`=0, only bits [31:0] of each operand are used, and bit 31 is the sign in signed mode. The 32-bit quotient and remainder are sign-extended to 64 bits when `signed_i`=1 and zero-extended when `signed_i`=0.
- R4: Count the rising edge that samples `start_i` as edge 1. For a nonzero divisor, `done_o` is high after edge 2N+5, where N=64 when `wide_i`=1 and N=32 when `wide_i`=0. That gives 133 and 69 cycles.
- R5: `done_o` is high for exactly one cycle per operation. `quotient_o`, `remainder_o` and `div_zero_o` change only at a completion and hold their values between completions.
- R6: A `start_i` pulse that arrives while an operation is in progress has no effect. It changes neither the running operation's results nor its completion cycle. A start in the cycle where `done_o` is high is accepted.
- R7: A zero divisor (judged on the bits in use for the mode) gives `done_o` after edge 3. It sets `div_zero_o`=1 and returns a quotient of all ones and a remainder equal to the dividend, both extended as in R3. Every other completion clears `div_zero_o`.
- R8: In signed mode, the most negative value divided by −1 returns the most negative value as quotient and zero as remainder, with `div_zero_o`=0.
- R9: After synchronous reset, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all zero.
- R10: Operands, sign select and mode are taken only in the cycle that starts an operation. Changes on those inputs afterwards do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| signed_i | input | 1 | 1: two's complement operands, 0: unsigned |
| wide_i | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| quotient_o | output | 64 | Quotient of the last completed division |
| remainder_o | output | 64 | Remainder of the last completed division |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed division had a zero divisor |

## Verification
The assertions assume that reset is held low for at least one rising edge before any activity. They also assume that every input carries a defined value at each edge, including edges where `start_i` is low, since the latency and hold checks read the state captured at the start cycle. The stimulus drives all inputs from time zero and releases reset only after several edges. It places fresh random values on the operands, sign select and mode in every cycle where no operation is being started. It raises `start_i` during a busy period only at cycles chosen deliberately, including the final cycle before completion.

// File: rtl/nrd_pkg.sv
// Package nrd_pkg
// Shared state encoding for the non-restoring divider. It holds no widths;
// every size comes from the parameters of the modules that import it.
package nrd_pkg;

    // Sequencer states. ST_SHIFT and ST_STEP together form one iteration.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_INIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_STEP  = 3'd4,
        ST_FIX   = 3'd5,
        ST_SIGN  = 3'd6
    } nrd_state_e;

endpackage

// File: rtl/nrd_csel_adder.sv
// Module nrd_csel_adder
// Computes op_a + op_b when sub=0 and op_a - op_b when sub=1.
// It is a carry-select adder: each block of BLK bits precomputes its sum for
// both carry-in values, and the ripple of block carries then picks one.
// Assumes: AW >= 1 and BLK >= 1. The top block may be narrower than BLK, and
// its carry-out is not produced.
module nrd_csel_adder #(
    parameter int unsigned AW  = 66,
    parameter int unsigned BLK = 16
) (
    input  logic [AW-1:0] op_a,
    input  logic [AW-1:0] op_b,
    input  logic          sub,
    output logic [AW-1:0] sum
);
    localparam int unsigned NB = (AW + BLK - 1) / BLK;

    logic [AW-1:0] b_x;
    logic [NB-1:0] blk_cin;

    // Invert the second operand for subtraction; the +1 enters as carry-in.
    assign b_x        = op_b ^ {AW{sub}};
    assign blk_cin[0] = sub;

    for (genvar g = 0; g < NB; g++) begin : g_blk
        localparam int unsigned LO = g * BLK;
        localparam int unsigned BW = ((AW - LO) < BLK) ? (AW - LO) : BLK;

        if (g == NB - 1) begin : g_top
            logic [BW-1:0] s0;
            logic [BW-1:0] s1;
            // Top block: both candidate sums, with no carry-out needed.
            assign s0 = op_a[LO +: BW] + b_x[LO +: BW];
            assign s1 = op_a[LO +: BW] + b_x[LO +: BW] + BW'(1);
            assign sum[LO +: BW] = blk_cin[g] ? s1 : s0;
        end else begin : g_mid
            logic [BW:0] s0;
            logic [BW:0] s1;
            // Inner block: both candidate sums, each with its own carry-out.
            assign s0 = {1'b0, op_a[LO +: BW]} + {1'b0, b_x[LO +: BW]};
            assign s1 = {1'b0, op_a[LO +: BW]} + {1'b0, b_x[LO +: BW]} + (BW+1)'(1);
            assign sum[LO +: BW] = blk_cin[g] ? s1[BW-1:0] : s0[BW-1:0];
            assign blk_cin[g+1]  = blk_cin[g] ? s1[BW] : s0[BW];
        end
    end

endmodule

// File: rtl/nrd_operand_prep.sv
// Module nrd_operand_prep
// Combinational operand conditioning. It picks the active width, converts
// each operand to its magnitude in signed mode, and derives the result sign
// rules and the zero-divisor condition.
// Assumes: W is even. Half-width operands sit in bits [W/2-1:0], and the
// magnitude comes back zero-extended to W bits.
module nrd_operand_prep #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    input  logic         signed_i,
    input  logic         wide_i,
    output logic [W-1:0] mag_a_o,
    output logic [W-1:0] mag_b_o,
    output logic         neg_quo_o,
    output logic         neg_rem_o,
    output logic         zero_div_o
);
    localparam int unsigned HW = W / 2;

    logic [1:0][W-1:0] raw;
    logic [1:0][W-1:0] mag;
    logic [1:0]        neg;

    // Index 0 is the dividend and index 1 is the divisor.
    assign raw[0] = dividend_i;
    assign raw[1] = divisor_i;

    for (genvar g = 0; g < 2; g++) begin : g_opnd
        logic [HW-1:0] lo;
        logic [HW-1:0] lo_n;
        assign lo   = raw[g][HW-1:0];
        assign lo_n = (~lo) + HW'(1);
        // An operand is negative only in signed mode, read at the mode's top bit.
        assign neg[g] = signed_i & (wide_i ? raw[g][W-1] : lo[HW-1]);
        // Magnitude of the operand at the selected width.
        assign mag[g] = !neg[g] ? (wide_i ? raw[g] : W'(lo))
                                : (wide_i ? ((~raw[g]) + W'(1)) : W'(lo_n));
    end

    // The result signs follow the operand signs; zero is judged on the magnitude.
    assign mag_a_o    = mag[0];
    assign mag_b_o    = mag[1];
    assign neg_quo_o  = neg[0] ^ neg[1];
    assign neg_rem_o  = neg[0];
    assign zero_div_o = (mag[1] == '0);

endmodule

// File: rtl/nrd_seq_ctrl.sv
// Module nrd_seq_ctrl
// Sequencer for the divider. It steps through operand capture, magnitude
// load, loop setup, two cycles per iteration, remainder correction and sign
// restore. It counts the iterations: W for the wide mode and W/2 for the
// narrow mode.
// Assumes: wide_i and zero_div_i are held stable by the datapath while busy.
module nrd_seq_ctrl
    import nrd_pkg::*;
#(
    parameter int unsigned W = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       wide_i,
    input  logic       zero_div_i,
    output nrd_state_e state_o,
    output logic       last_o
);
    localparam int unsigned CW = $clog2(W + 1);

    nrd_state_e    state_n;
    logic [CW-1:0] iter_cnt;

    assign last_o = (iter_cnt == CW'(1));

    // Choose the next state from the current state and the loop position.
    always_comb begin
        state_n = state_o;
        case (state_o)
            ST_IDLE:  if (start_i) state_n = ST_LOAD;
            ST_LOAD:  state_n = ST_INIT;
            ST_INIT:  state_n = zero_div_i ? ST_IDLE : ST_SHIFT;
            ST_SHIFT: state_n = ST_STEP;
            ST_STEP:  state_n = last_o ? ST_FIX : ST_SHIFT;
            ST_FIX:   state_n = ST_SIGN;
            ST_SIGN:  state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= state_n;
    end

    // Iteration counter: loaded at loop setup, decremented at each add/sub phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                  iter_cnt <= '0;
        else if (state_o == ST_INIT) iter_cnt <= wide_i ? CW'(W) : CW'(W / 2);
        else if (state_o == ST_STEP) iter_cnt <= iter_cnt - CW'(1);
    end

endmodule

// File: rtl/nr_divider.sv
// Module nr_divider (top)
// Sequential non-restoring integer divider with one quotient bit per
// two-cycle iteration. It captures the operands on start, divides their
// magnitudes, corrects a negative final remainder by one add of the divisor,
// then restores signs and extends the results for the half-width mode.
// Assumes: W is even. start_i is ignored unless the block is idle.
module nr_divider
    import nrd_pkg::*;
#(
    parameter int unsigned W        = 64,
    parameter int unsigned CSEL_BLK = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic         wide_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic [W-1:0] remainder_o,
    output logic         done_o,
    output logic         div_zero_o
);
    localparam int unsigned HW = W / 2;
    localparam int unsigned RW = W + 2;   // partial remainder plus sign and headroom

    nrd_state_e    state;
    logic          last_step;
    logic          busy;
    logic          at_sign;

    logic [W-1:0]  a_q, b_q;
    logic          sgn_q, wide_q;
    logic [W-1:0]  prep_a, prep_b;
    logic          prep_nq, prep_nr, prep_z;
    logic [W-1:0]  mag_a_q, mag_b_q;
    logic          neg_quo_q, neg_rem_q, zero_q;
    logic [RW-1:0] rem_q;
    logic [W-1:0]  quo_q;
    logic [RW-1:0] add_sum;
    logic          add_sub;
    logic [W-1:0]  quo_signed, rem_signed;

    assign busy    = (state != ST_IDLE);
    assign at_sign = (state == ST_SIGN);

    // Narrow results are extended from the half-width value; wide ones pass through.
    function automatic logic [W-1:0] fit_result(input logic [W-1:0] x,
                                                input logic sgn, input logic wide);
        if (wide)     return x;
        else if (sgn) return {{HW{x[HW-1]}}, x[HW-1:0]};
        else          return {{HW{1'b0}}, x[HW-1:0]};
    endfunction

    nrd_seq_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .wide_i     (wide_q),
        .zero_div_i (zero_q),
        .state_o    (state),
        .last_o     (last_step)
    );

    nrd_operand_prep #(.W(W)) u_prep (
        .dividend_i (a_q),
        .divisor_i  (b_q),
        .signed_i   (sgn_q),
        .wide_i     (wide_q),
        .mag_a_o    (prep_a),
        .mag_b_o    (prep_b),
        .neg_quo_o  (prep_nq),
        .neg_rem_o  (prep_nr),
        .zero_div_o (prep_z)
    );

    // Subtract when the shifted remainder is non-negative; the correction always adds.
    assign add_sub = (state == ST_STEP) && !rem_q[RW-1];

    nrd_csel_adder #(.AW(RW), .BLK(CSEL_BLK)) u_add (
        .op_a (rem_q),
        .op_b (RW'(mag_b_q)),
        .sub  (add_sub),
        .sum  (add_sum)
    );

    // Capture the raw operands and mode only when an operation is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            sgn_q  <= 1'b0;
            wide_q <= 1'b0;
        end else if (state == ST_IDLE && start_i) begin
            a_q    <= dividend_i;
            b_q    <= divisor_i;
            sgn_q  <= signed_i;
            wide_q <= wide_i;
        end
    end

    // Register the magnitudes and sign rules one cycle after capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_a_q   <= '0;
            mag_b_q   <= '0;
            neg_quo_q <= 1'b0;
            neg_rem_q <= 1'b0;
            zero_q    <= 1'b0;
        end else if (state == ST_LOAD) begin
            mag_a_q   <= prep_a;
            mag_b_q   <= prep_b;
            neg_quo_q <= prep_nq;
            neg_rem_q <= prep_nr;
            zero_q    <= prep_z;
        end
    end

    // Division core: loop setup, shift phase, add/sub phase, final correction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
        end else begin
            case (state)
                ST_INIT: begin
                    rem_q <= '0;
                    quo_q <= wide_q ? mag_a_q : (mag_a_q << HW);
                end
                ST_SHIFT: begin
                    rem_q <= {rem_q[RW-2:0], quo_q[W-1]};
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                ST_STEP: begin
                    rem_q    <= add_sum;
                    quo_q[0] <= ~add_sum[RW-1];
                end
                ST_FIX: begin
                    if (rem_q[RW-1]) rem_q <= add_sum;
                end
                default: ;
            endcase
        end
    end

    // Apply the result signs to the unsigned quotient and the corrected remainder.
    assign quo_signed = neg_quo_q ? ((~quo_q) + W'(1)) : quo_q;
    assign rem_signed = neg_rem_q ? ((~rem_q[W-1:0]) + W'(1)) : rem_q[W-1:0];

    // Result registers and the completion pulse for both normal and zero-divisor paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient_o  <= '0;
            remainder_o <= '0;
            done_o      <= 1'b0;
            div_zero_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state == ST_SIGN) begin
                quotient_o  <= fit_result(quo_signed, sgn_q, wide_q);
                remainder_o <= fit_result(rem_signed, sgn_q, wide_q);
                div_zero_o  <= 1'b0;
                done_o      <= 1'b1;
            end else if (state == ST_INIT && zero_q) begin
                quotient_o  <= fit_result('1, sgn_q, wide_q);
                remainder_o <= fit_result(a_q, sgn_q, wide_q);
                div_zero_o  <= 1'b1;
                done_o      <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/nrd_checker.sv
// Module nrd_checker
// Temporal properties of nr_divider, attached by the bind statement below.
// It keeps its own cycle counter to measure completion latency, so no
// property needs a long delay.
module nrd_checker #(
    parameter int unsigned W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         done_o,
    input logic         div_zero_o,
    input logic [W-1:0] quotient_o,
    input logic [W-1:0] remainder_o,
    input logic         busy,
    input logic         at_sign,
    input logic         wide_q,
    input logic [W-1:0] a_q,
    input logic [W+1:0] rem_q,
    input logic [W-1:0] mag_b_q
);
    localparam int unsigned HW = W / 2;
    localparam int unsigned LW = $clog2(2 * W + 8) + 1;

    logic [LW-1:0] lat_cnt;

    // Count edges from the accepting edge (value 1) through the busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)                 lat_cnt <= '0;
        else if (!busy && start_i)  lat_cnt <= LW'(1);
        else if (busy)              lat_cnt <= lat_cnt + LW'(1);
        else                        lat_cnt <= '0;
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_cnt == (div_zero_o ? LW'(3) : (wide_q ? LW'(2 * W + 5) : LW'(W + 5)))));

    p_flag_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_zero_o) |-> done_o);

    p_zero_quotient_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> (quotient_o[HW-1:0] == '1));

    p_rem_corrected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        at_sign |-> (rem_q < {2'b00, mag_b_q}));

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> ($stable(a_q) && $stable(wide_q)));

endmodule

bind nr_divider nrd_checker #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .div_zero_o  (div_zero_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .busy        (busy),
    .at_sign     (at_sign),
    .wide_q      (wide_q),
    .a_q         (a_q),
    .rem_q       (rem_q),
    .mag_b_q     (mag_b_q)
);

// File: tb/nr_divider_tb.sv
`timescale 1ns/1ps
// Bench for nr_divider. A behavioural reference model computes each result
// with plain integer arithmetic. A countdown predicts the completion cycle,
// and all outputs are compared at every falling edge.
module nr_divider_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sgn = 1'b0;
    logic        wide = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [63:0] quotient_o, remainder_o;
    logic        done_o, div_zero_o;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    busy = 0;
    int    left = 0;
    logic [63:0] pq, pr;
    bit    pdz;
    string ptag = "R1";
    string cur_tag = "R1";
    logic [63:0] eq = '0, er = '0;
    bit    edz = 0, edone = 0;

    always #5 clk = ~clk;

    nr_divider u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .signed_i    (sgn),
        .wide_i      (wide),
        .dividend_i  (a),
        .divisor_i   (b),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .done_o      (done_o),
        .div_zero_o  (div_zero_o)
    );

    function automatic logic [63:0] widen(logic [31:0] x, bit s);
        return s ? {{32{x[31]}}, x} : {32'h0, x};
    endfunction

    // Reference results from the requirement text (R1, R2, R3, R7, R8).
    task automatic model(input logic [63:0] da, input logic [63:0] db, input bit s,
                         input bit w, output logic [63:0] q, output logic [63:0] r,
                         output bit dz);
        if (w) begin
            bit an, bn;
            logic [63:0] ma, mb, qm, rm;
            dz = (db == 64'd0);
            if (dz) begin q = '1; r = da; end
            else begin
                an = s & da[63]; bn = s & db[63];
                ma = an ? (64'd0 - da) : da;
                mb = bn ? (64'd0 - db) : db;
                qm = ma / mb; rm = ma % mb;
                q  = (an ^ bn) ? (64'd0 - qm) : qm;
                r  = an ? (64'd0 - rm) : rm;
            end
        end else begin
            bit an, bn;
            logic [31:0] a32, b32, ma, mb, qm, rm, q32, r32;
            a32 = da[31:0]; b32 = db[31:0];
            dz = (b32 == 32'd0);
            if (dz) begin q32 = '1; r32 = a32; end
            else begin
                an = s & a32[31]; bn = s & b32[31];
                ma = an ? (32'd0 - a32) : a32;
                mb = bn ? (32'd0 - b32) : b32;
                qm = ma / mb; rm = ma % mb;
                q32 = (an ^ bn) ? (32'd0 - qm) : qm;
                r32 = an ? (32'd0 - rm) : rm;
            end
            q = widen(q32, s); r = widen(r32, s);
        end
    endtask

    task automatic check(input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle of inputs, advance to the next falling edge, and compare.
    task automatic tick(input bit st, input logic [63:0] da, input logic [63:0] db,
                        input bit ds, input bit dw);
        string vtag;
        start = st; a = da; b = db; sgn = ds; wide = dw;
        if (st && !busy) begin
            model(da, db, ds, dw, pq, pr, pdz);
            ptag = cur_tag;
            busy = 1;
            left = pdz ? 3 : (dw ? 133 : 69);   // R4 and R7 latencies
        end
        @(negedge clk);
        edone = 0;
        if (busy) begin
            left--;
            if (left == 0) begin
                busy = 0; edone = 1; eq = pq; er = pr; edz = pdz;
            end
        end
        check("R4", "done", 64'(done_o), 64'(edone));
        vtag = edone ? ptag : "R5";
        check(vtag, "quotient", quotient_o, eq);
        check(vtag, "remainder", remainder_o, er);
        check(vtag, "div_zero", 64'(div_zero_o), 64'(edz));
    endtask

    // One operation. Inputs are scrambled after the start cycle (R10). If
    // inject is nonzero, a second start is raised at that busy cycle (R6).
    task automatic run_op(input logic [63:0] da, input logic [63:0] db, input bit ds,
                          input bit dw, input string tag, input int inject);
        int i;
        cur_tag = tag;
        tick(1'b1, da, db, ds, dw);
        i = 0;
        while (busy) begin
            i++;
            if (inject != 0 && i == inject)
                tick(1'b1, ~da, db + 64'd1, ~ds, ~dw);
            else
                tick(1'b0, {$urandom, $urandom}, {$urandom, $urandom},
                     1'($urandom), 1'($urandom));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset values
        check("R9", "done", 64'(done_o), 64'd0);
        check("R9", "quotient", quotient_o, 64'd0);
        check("R9", "remainder", remainder_o, 64'd0);
        check("R9", "div_zero", 64'(div_zero_o), 64'd0);
        tick(1'b0, '0, '0, 1'b0, 1'b0);

        // R1: unsigned 64-bit
        run_op(64'd100, 64'd7, 1'b0, 1'b1, "R1", 0);
        run_op('1, 64'd1, 1'b0, 1'b1, "R1", 0);
        run_op('1, '1, 1'b0, 1'b1, "R1", 0);
        run_op(64'd5, 64'd10, 1'b0, 1'b1, "R1", 0);
        run_op('1, 64'd3, 1'b0, 1'b1, "R1", 0);
        run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, "R1", 0);
        for (int k = 0; k < 3; k++)
            run_op({$urandom, $urandom}, {32'h0, $urandom} | 64'd1, 1'b0, 1'b1, "R1", 0);

        // R2: signed 64-bit, truncation toward zero
        run_op(-64'sd100, 64'd7, 1'b1, 1'b1, "R2", 0);
        run_op(64'd100, -64'sd7, 1'b1, 1'b1, "R2", 0);
        run_op(-64'sd100, -64'sd7, 1'b1, 1'b1, "R2", 0);
        run_op(64'd7, -64'sd100, 1'b1, 1'b1, "R2", 0);
        run_op(-64'sd1, 64'd2, 1'b1, 1'b1, "R2", 0);

        // R3: 32-bit mode ignores the upper operand bits and extends results
        run_op(64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 1'b0, 1'b0, "R3", 0);
        run_op(64'h0BAD_F00D_FFFF_FF9C, 64'hFFFF_0000_0000_0007, 1'b1, 1'b0, "R3", 0);
        run_op(64'h0000_0001_0000_0064, 64'h0000_0000_FFFF_FFF9, 1'b1, 1'b0, "R3", 0);
        run_op(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1'b0, 1'b0, "R3", 0);

        // R7: zero divisor in both modes, with divisor upper bits set in narrow mode
        run_op(64'h0123_4567_89AB_CDEF, 64'd0, 1'b0, 1'b1, "R7", 0);
        run_op(-64'sd55, 64'd0, 1'b1, 1'b1, "R7", 0);
        run_op(64'h7777_7777_8000_0005, 64'hFFFF_0000_0000_0000, 1'b1, 1'b0, "R7", 0);
        run_op(64'h7777_7777_8000_0005, 64'h0000_0001_0000_0000, 1'b0, 1'b0, "R7", 0);

        // R8: most negative divided by minus one
        run_op(64'h8000_0000_0000_0000, '1, 1'b1, 1'b1, "R8", 0);
        run_op(64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1, 1'b0, "R8", 0);

        // R6: start while busy, early and in the cycle before completion
        run_op(64'd1000, 64'd33, 1'b0, 1'b1, "R6", 10);
        run_op(64'd1000, 64'd33, 1'b0, 1'b0, "R6", 68);
        run_op(64'd999, 64'd0, 1'b0, 1'b1, "R6", 2);
        run_op(-64'sd12345, 64'd77, 1'b1, 1'b1, "R6", 132);

        // R10: random mixes in both modes with operands scrambled while busy
        for (int k = 0; k < 6; k++)
            run_op({$urandom, $urandom}, {$urandom, $urandom} | 64'd1,
                   1'(k), 1'(k >> 1), "R10", 0);

        repeat (3) tick(1'b0, '0, '0, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #2000000;
        n_bad++;
        $display("FAIL R4 watchdog expired: got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule